// File: doc/BRIEF.md
# Instruction Decode and Phase Timing Front End

This block sits at the head of the control path of a small 16-bit accumulator machine. When told to, it captures a fetched instruction word and splits it three ways. The top bit is kept in its own indirect flag. The next three bits form the operation code, which drives a one-hot set of eight operation lines. The low twelve bits are handed on unchanged as the address or operand part.

Alongside the decode, a 4-bit step counter sets the timing of an instruction. The control logic above it can clear the counter or advance it, and its value is turned into sixteen one-hot phase strobes. That logic combines operation lines, phase strobes and the indirect flag to run the micro-operations, which are not part of this block.

All registers use a synchronous, active-low reset. The decoded outputs depend only on the registers, so they change just after a clock edge and never follow an input directly.

Top module: `instr_ctl_front`

## Requirements
- R1: On a clock edge with `rst_n` low, the instruction register, the indirect flag and the step counter all clear. Afterwards `op_line` is 8'h01, `phase` is 16'h0001, `ind_bit` is 0 and `addr_field` is 0.
- R2: On a clock edge with `ir_load` high, `addr_field` takes `ir_word[11:0]`.
- R3: On a clock edge with `ir_load` high, `ind_bit` takes `ir_word[15]`.
- R4: After a load, exactly bit k of `op_line` is high, where k is the value of `ir_word[14:12]` (0 to 7).
- R5: On a clock edge with `ir_load` low, `op_line`, `ind_bit` and `addr_field` keep their values, whatever `ir_word` is.
- R6: `phase` is one-hot, and its set bit index equals the step count (0 to 15).
- R7: On a clock edge with `seq_inc` high and `seq_clr` low, the step count rises by one.
- R8: Incrementing from step 15 gives step 0, so `phase` goes from 16'h8000 to 16'h0001.
- R9: On a clock edge with `seq_clr` high, the step count becomes 0, even if `seq_inc` is also high.
- R10: On a clock edge with both `seq_clr` and `seq_inc` low, the step count holds.
- R11: Outside reset, exactly one bit of `op_line` and exactly one bit of `phase` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_load | input | 1 | Capture `ir_word` into the instruction register |
| ir_word | input | 16 | Fetched instruction word |
| seq_clr | input | 1 | Synchronous clear of the step counter (takes priority) |
| seq_inc | input | 1 | Advance the step counter by one |
| op_line | output | 8 | One-hot decoded operation code |
| phase | output | 16 | One-hot timing strobes from the step counter |
| ind_bit | output | 1 | Indirect flag captured from bit 15 |
| addr_field | output | 12 | Address/operand part of the instruction |

## Verification
Some properties are checked on every cycle: both output groups are one-hot, a load puts the word's fields on the outputs, fields hold when there is no load, clear wins over increment, the counter steps by one and wraps, and reset returns to the idle state. Other behaviour only shows up in the bench's scenarios. These include that all eight opcode values land on the correct line, that an indirect flag combines correctly with each address pattern, and that a long run of increments visits all sixteen phases in order and wraps back.

// File: rtl/ctl_front_pkg.sv
// Package: shared widths and field layout of the instruction word.
// Assumes a word made of flag | opcode | address, most significant first.
package ctl_front_pkg;
    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned OP_W_DEF   = 3;
    localparam int unsigned SEQ_W_DEF  = 4;

    // Address width implied by the flag + opcode + address split.
    function automatic int unsigned addr_width(input int unsigned word_w, input int unsigned op_w);
        return word_w - op_w - 1;
    endfunction
endpackage

// File: rtl/instr_latch.sv
// Module: instruction register with a separate indirect flag.
// Captures the word on a load-enabled edge and exposes its opcode and
// address parts. Assumes WORD_W = 1 + OP_W + ADDR_W.
module instr_latch #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OP_W   = 3,
    parameter int unsigned ADDR_W = WORD_W - OP_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] addr,
    output logic              ind
);
    localparam int unsigned OP_LO = ADDR_W;
    localparam int unsigned OP_HI = ADDR_W + OP_W - 1;

    logic [OP_HI:0] ir_q;
    logic           ind_q;

    // Load the opcode and address part when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (load) begin
            ir_q <= word[OP_HI:0];
        end
    end

    // The indirect flag is its own flip-flop, loaded with the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q <= 1'b0;
        end else if (load) begin
            ind_q <= word[WORD_W-1];
        end
    end

    assign opcode = ir_q[OP_HI:OP_LO];
    assign addr   = ir_q[ADDR_W-1:0];
    assign ind    = ind_q;
endmodule

// File: rtl/step_counter.sv
// Module: binary step counter for instruction timing.
// Counts 0..2**SEQ_W-1 and wraps. A clear wins over an increment.
module step_counter #(
    parameter int unsigned SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [SEQ_W-1:0] count
);
    logic [SEQ_W-1:0] cnt_q;

    // Clear has priority; the increment wraps naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + SEQ_W'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/onehot_dec.sv
// Module: generic binary-to-one-hot decoder.
// Purely combinational. Output bit i is high when sel equals i.
module onehot_dec #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] lines
);
    // One comparator per output line.
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign lines[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/instr_ctl_front.sv
// Module: decode and timing front end of the hardwired control unit.
// Holds the instruction, decodes its opcode into one-hot operation
// lines and decodes the step counter into one-hot phase strobes.
// Assumes the control logic above it drives clear and increment.
module instr_ctl_front #(
    parameter int unsigned WORD_W = ctl_front_pkg::WORD_W_DEF,
    parameter int unsigned OP_W   = ctl_front_pkg::OP_W_DEF,
    parameter int unsigned SEQ_W  = ctl_front_pkg::SEQ_W_DEF,
    parameter int unsigned ADDR_W = ctl_front_pkg::addr_width(WORD_W, OP_W),
    parameter int unsigned OP_N   = 1 << OP_W,
    parameter int unsigned PH_N   = 1 << SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_load,
    input  logic [WORD_W-1:0] ir_word,
    input  logic              seq_clr,
    input  logic              seq_inc,
    output logic [OP_N-1:0]   op_line,
    output logic [PH_N-1:0]   phase,
    output logic              ind_bit,
    output logic [ADDR_W-1:0] addr_field
);
    logic [OP_W-1:0]  opcode;
    logic [SEQ_W-1:0] step;

    instr_latch #(.WORD_W(WORD_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .load(ir_load), .word(ir_word),
        .opcode(opcode), .addr(addr_field), .ind(ind_bit)
    );

    step_counter #(.SEQ_W(SEQ_W)) u_sc (
        .clk(clk), .rst_n(rst_n), .clr(seq_clr), .inc(seq_inc), .count(step)
    );

    onehot_dec #(.SEL_W(OP_W), .OUT_N(OP_N)) u_op_dec (
        .sel(opcode), .lines(op_line)
    );

    onehot_dec #(.SEL_W(SEQ_W), .OUT_N(PH_N)) u_ph_dec (
        .sel(step), .lines(phase)
    );
endmodule

// File: rtl/instr_ctl_front_chk.sv
// Module: property checker for instr_ctl_front, attached by bind.
// Observes the ports only. Assumes the synchronous active-low reset.
module instr_ctl_front_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OP_N   = 8,
    parameter int unsigned PH_N   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ir_load,
    input logic [WORD_W-1:0] ir_word,
    input logic              seq_clr,
    input logic              seq_inc,
    input logic [OP_N-1:0]   op_line,
    input logic [PH_N-1:0]   phase,
    input logic              ind_bit,
    input logic [ADDR_W-1:0] addr_field
);
    logic armed;

    // Note that at least one reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
        else if (armed !== 1'b1) armed <= 1'b0;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1 && !$past(rst_n)) |->
        (op_line == OP_N'(1) && phase == PH_N'(1) && !ind_bit && addr_field == '0));

    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ir_load)) |-> addr_field == $past(ir_word[ADDR_W-1:0]));

    p_load_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ir_load)) |-> ind_bit == $past(ir_word[WORD_W-1]));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ir_load)) |->
        ($stable(op_line) && $stable(ind_bit) && $stable(addr_field)));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(seq_clr) && $past(seq_inc) && !$past(phase[PH_N-1])) |->
        phase == ($past(phase) << 1));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(seq_clr) && $past(seq_inc) && $past(phase[PH_N-1])) |->
        phase == PH_N'(1));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(seq_clr)) |-> phase == PH_N'(1));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(seq_clr) && !$past(seq_inc)) |-> $stable(phase));

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1) |-> ($countones(op_line) == 1 && $countones(phase) == 1));
endmodule

bind instr_ctl_front instr_ctl_front_chk #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_N(OP_N), .PH_N(PH_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_word(ir_word),
    .seq_clr(seq_clr), .seq_inc(seq_inc), .op_line(op_line), .phase(phase),
    .ind_bit(ind_bit), .addr_field(addr_field)
);

// File: tb/instr_ctl_front_tb.sv
// Scoreboard bench: the driver computes the expected outputs from the
// requirements and queues them; the monitor pops and compares at negedge.
module instr_ctl_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic [15:0] ir_word = '0;
    logic        seq_clr = 1'b0;
    logic        seq_inc = 1'b0;
    logic [7:0]  op_line;
    logic [15:0] phase;
    logic        ind_bit;
    logic [11:0] addr_field;

    typedef struct {
        logic [7:0]  op;
        logic [15:0] ph;
        logic        ind;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // bench-side model state
    logic [2:0]  m_op = '0;
    logic [3:0]  m_step = '0;
    logic        m_ind = 1'b0;
    logic [11:0] m_addr = '0;

    always #10 clk = ~clk;   // 50 MHz

    instr_ctl_front u_dut (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_word(ir_word),
        .seq_clr(seq_clr), .seq_inc(seq_inc), .op_line(op_line), .phase(phase),
        .ind_bit(ind_bit), .addr_field(addr_field)
    );

    // Drive one cycle, update the model, queue the expected outputs.
    task automatic step(input logic rst, input logic ld, input logic [15:0] w,
                        input logic clr, input logic inc, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rst; ir_load = ld; ir_word = w; seq_clr = clr; seq_inc = inc;
        @(posedge clk);
        if (rst) begin
            m_op = '0; m_step = '0; m_ind = 1'b0; m_addr = '0;
        end else begin
            if (ld) begin
                m_op = w[14:12]; m_ind = w[15]; m_addr = w[11:0];
            end
            if (clr) m_step = '0;
            else if (inc) m_step = m_step + 4'd1;
        end
        e.op = 8'(1) << m_op;
        e.ph = 16'(1) << m_step;
        e.ind = m_ind;
        e.addr = m_addr;
        e.tag = tag;
        #1 exp_q.push_back(e);
    endtask

    // Monitor: compare outputs against the queue away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (op_line !== e.op || phase !== e.ph || ind_bit !== e.ind ||
                    addr_field !== e.addr) begin
                    errors++;
                    $display("FAIL %s: got op=%h ph=%h ind=%b addr=%h exp op=%h ph=%h ind=%b addr=%h",
                             e.tag, op_line, phase, ind_bit, addr_field,
                             e.op, e.ph, e.ind, e.addr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, 1, 16'hFFFF, 0, 1, "R1");
        step(1, 0, 16'h0000, 0, 0, "R1");
        step(0, 0, 16'h0000, 0, 0, "R1");
        // R2 R3 R4: every opcode, with and without the indirect flag
        for (int k = 0; k < 8; k++) begin
            step(0, 1, {k[0], k[2:0], 12'hA50 ^ 12'(k * 291)}, 0, 0, "R4");
        end
        step(0, 1, 16'h8FFF, 0, 0, "R2");
        step(0, 1, 16'h7001, 0, 0, "R3");
        // R5: word changes without load are ignored
        step(0, 0, 16'hFFFF, 0, 0, "R5");
        step(0, 0, 16'h0000, 0, 1, "R5");
        // R6 R7 R8: walk all phases and wrap
        for (int k = 0; k < 18; k++) step(0, 0, 16'h1234, 0, 1, "R7");
        step(0, 0, 16'h0, 0, 0, "R10");
        step(0, 0, 16'h0, 0, 0, "R10");
        // R9: clear alone and clear with increment
        step(0, 0, 16'h0, 1, 0, "R9");
        for (int k = 0; k < 5; k++) step(0, 0, 16'h0, 0, 1, "R6");
        step(0, 0, 16'h0, 1, 1, "R9");
        step(0, 0, 16'h0, 0, 1, "R8");
        // load and count together
        step(0, 1, 16'hD3C7, 0, 1, "R11");
        // mid-run reset
        step(1, 0, 16'h0, 0, 1, "R1");
        step(0, 0, 16'h0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: got %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule